// File: doc/BRIEF.md
# Branch Decode and Resolve Unit

This unit takes one 32-bit instruction word, the address it was fetched from, the two general-register values read for it, and an eight-entry vector of one-bit condition flags. From these it works out the control-flow outcome, one cycle later.

It recognises the branch and jump group of opcodes. It rebuilds the scaled, sign-extended offset from instruction fields that need not be adjacent, and evaluates the branch condition. It reports the next fetch address, whether the branch was taken, and whether the word was a branch at all. For call-type jumps it also raises a link-register write request.

A pipeline drives `in_valid` together with the operands. It uses the registered result, marked by `out_valid`, to redirect fetch and to schedule the link write. The unit has no other state.

Top module: `branch_resolve_unit`

## Requirements
- R1: Opcode bits [31:26] select the group: 010000 zero-test, 010001 nonzero-test, 010010 flag test, 010011 register jump with link, 010100 unconditional, 010101 call, and 010110 to 011011 the compares eq, ne, lt, ge, ltu, geu in that order. Any other opcode sets `out_not_branch` and gives next PC = PC + 4, taken 0 and no link write.
- R2: The zero-test and nonzero-test forms compare the rj operand (`rj_val`, index in bits [9:5]) with zero.
- R3: For opcode 010010, bits [9:8] = 00 takes the branch when `cflags[cj]` is 0, and 01 takes it when the flag is 1, where cj = bits [7:5]. Bits [9:8] = 10 or 11 are treated as not a branch.
- R4: The two-register compares test `rj_val` against `rd_val`. The eq and ne forms test equality. The lt and ge forms are signed, and the ltu and geu forms are unsigned. The ge and geu forms are true on equality.
- R5: The compare forms and the register jump use offset = sign-extend(bits [25:10]) × 4.
- R6: The zero, nonzero and flag forms use offset = sign-extend({bits [4:0], bits [25:10]}) × 4.
- R7: The unconditional and call forms use offset = sign-extend({bits [9:0], bits [25:10]}) × 4.
- R8: A taken PC-relative branch yields next PC = PC + offset. A branch that is not taken yields PC + 4.
- R9: The unconditional and call forms are always taken. The call form requests a write of PC + 4 into register 1.
- R10: The register jump is always taken. It targets `rj_val` + offset and requests a write of PC + 4 into register rd (bits [4:0]). The target uses the input operand even when rd equals rj.
- R11: A link write whose destination is register 0 is suppressed.
- R12: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. The result fields change only on such cycles. A synchronous active-high reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands below are valid this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| rj_val | input | 64 | Value of register rj |
| rd_val | input | 64 | Value of register rd |
| cflags | input | 8 | Condition flag vector |
| out_valid | output | 1 | Result registered from the previous valid input |
| out_next_pc | output | 64 | Next fetch address |
| out_taken | output | 1 | Control transfer taken |
| out_not_branch | output | 1 | Word is outside the branch group |
| out_link_we | output | 1 | Link register write request |
| out_link_idx | output | 5 | Link register index |
| out_link_data | output | 64 | Link value (PC + 4) |

## Verification
A wrong decode or a corrupted offset in this unit shows up as a wrong `out_next_pc` one cycle after the instruction is presented. It cannot hide, because each vector pins the exact target. A mis-selected condition shows as a flipped `out_taken` in that same cycle. Wrong link state shows as a stray or missing `out_link_we`, or a wrong index, on the cycle that follows the call. A valid strobe that sticks or drops is visible within one cycle of the next idle input.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int INSN_W  = 32;
    localparam int REG_W   = 5;
    localparam int CJ_W    = 3;
    localparam int NFLAG   = 1 << CJ_W;
    localparam int OFF_RAW = 28;   // widest offset (26 bits) scaled by 4

    typedef enum logic [3:0] {
        K_NONE, K_BEQZ, K_BNEZ, K_BCF, K_JRL, K_B, K_BL,
        K_EQ, K_NE, K_LT, K_GE, K_LTU, K_GEU
    } br_kind_e;

    typedef enum logic [1:0] { OFF_16, OFF_21, OFF_26 } off_sel_e;

    typedef struct packed {
        br_kind_e          kind;
        logic [REG_W-1:0]  rj_idx;
        logic [REG_W-1:0]  rd_idx;
        logic [CJ_W-1:0]   cj;
        logic              cf_sense;   // 1: take when flag set
        off_sel_e          off_sel;
    } br_dec_t;

    function automatic br_dec_t decode_word(input logic [INSN_W-1:0] w);
        br_dec_t d;
        d.kind     = K_NONE;
        d.rj_idx   = w[9:5];
        d.rd_idx   = w[4:0];
        d.cj       = w[7:5];
        d.cf_sense = w[8];
        d.off_sel  = OFF_16;
        unique case (w[31:26])
            6'b010000: begin d.kind = K_BEQZ; d.off_sel = OFF_21; end
            6'b010001: begin d.kind = K_BNEZ; d.off_sel = OFF_21; end
            6'b010010: begin
                d.kind    = w[9] ? K_NONE : K_BCF;
                d.off_sel = OFF_21;
            end
            6'b010011: d.kind = K_JRL;
            6'b010100: begin d.kind = K_B;  d.off_sel = OFF_26; end
            6'b010101: begin d.kind = K_BL; d.off_sel = OFF_26; end
            6'b010110: d.kind = K_EQ;
            6'b010111: d.kind = K_NE;
            6'b011000: d.kind = K_LT;
            6'b011001: d.kind = K_GE;
            6'b011010: d.kind = K_LTU;
            6'b011011: d.kind = K_GEU;
            default:   d.kind = K_NONE;
        endcase
        return d;
    endfunction

    function automatic logic [OFF_RAW-1:0] scaled_offset(input logic [INSN_W-1:0] w,
                                                         input off_sel_e sel);
        logic [OFF_RAW-1:0] o;
        unique case (sel)
            OFF_21:  o = {{5{w[4]}}, w[4:0], w[25:10], 2'b00};
            OFF_26:  o = {w[9:0], w[25:10], 2'b00};
            default: o = {{10{w[25]}}, w[25:10], 2'b00};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [INSN_W-1:0]  insn,
    output br_dec_t            dec,
    output logic [OFF_RAW-1:0] off_raw
);
    always_comb begin
        dec     = decode_word(insn);
        off_raw = scaled_offset(insn, dec.off_sel);
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  br_kind_e          kind,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [NFLAG-1:0]  cflags,
    input  logic [CJ_W-1:0]   cj,
    input  logic              cf_sense,
    output logic              taken
);
    logic a_zero, equal, lt_s, lt_u, flag;

    always_comb begin
        a_zero = (a == '0);
        equal  = (a == b);
        lt_s   = ($signed(a) < $signed(b));
        lt_u   = (a < b);
        flag   = cflags[cj];
        unique case (kind)
            K_BEQZ:        taken = a_zero;
            K_BNEZ:        taken = !a_zero;
            K_BCF:         taken = (flag == cf_sense);
            K_JRL, K_B,
            K_BL:          taken = 1'b1;
            K_EQ:          taken = equal;
            K_NE:          taken = !equal;
            K_LT:          taken = lt_s;
            K_GE:          taken = !lt_s;
            K_LTU:         taken = lt_u;
            K_GEU:         taken = !lt_u;
            default:       taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import br_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int LINK_REG = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        insn,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    rj_val,
    input  logic [XLEN-1:0]    rd_val,
    input  logic [7:0]         cflags,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_next_pc,
    output logic               out_taken,
    output logic               out_not_branch,
    output logic               out_link_we,
    output logic [4:0]         out_link_idx,
    output logic [XLEN-1:0]    out_link_data
);
    localparam int EXT_W = XLEN - OFF_RAW;
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    br_dec_t            dec;
    logic [OFF_RAW-1:0] off_raw;
    logic               taken;
    logic [XLEN-1:0]    off_x, base, target, seq_pc, next_pc;
    logic               link_we;
    logic [REG_W-1:0]   link_idx;

    br_decode u_decode (
        .insn    (insn),
        .dec     (dec),
        .off_raw (off_raw)
    );

    br_cond #(.XLEN(XLEN)) u_cond (
        .kind     (dec.kind),
        .a        (rj_val),
        .b        (rd_val),
        .cflags   (cflags),
        .cj       (dec.cj),
        .cf_sense (dec.cf_sense),
        .taken    (taken)
    );

    always_comb begin
        off_x   = {{EXT_W{off_raw[OFF_RAW-1]}}, off_raw};
        base    = (dec.kind == K_JRL) ? rj_val : pc;
        target  = base + off_x;
        seq_pc  = pc + STEP;
        next_pc = taken ? target : seq_pc;
        unique case (dec.kind)
            K_BL:    begin link_idx = REG_W'(LINK_REG); link_we = 1'b1; end
            K_JRL:   begin link_idx = dec.rd_idx;       link_we = 1'b1; end
            default: begin link_idx = '0;               link_we = 1'b0; end
        endcase
        if (link_idx == '0) link_we = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        if (in_valid) begin
            out_next_pc    <= next_pc;
            out_taken      <= taken;
            out_not_branch <= (dec.kind == K_NONE);
            out_link_we    <= link_we;
            out_link_idx   <= link_idx;
            out_link_data  <= seq_pc;
        end
    end

    assert_valid_follow_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drop_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_fallthrough_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_taken || out_next_pc == $past(pc) + STEP));
    assert_notbr_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_not_branch) |-> (!out_taken && !out_link_we));
    assert_no_link_r0_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_link_we) |-> (out_link_idx != '0));
    assert_link_value_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_link_we || out_link_data == $past(pc) + STEP));
endmodule

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn;
    logic [63:0] pc, rj_val, rd_val;
    logic [7:0]  cflags;
    logic        out_valid, out_taken, out_not_branch, out_link_we;
    logic [63:0] out_next_pc, out_link_data;
    logic [4:0]  out_link_idx;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    branch_resolve_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .pc(pc),
        .rj_val(rj_val), .rd_val(rd_val), .cflags(cflags),
        .out_valid(out_valid), .out_next_pc(out_next_pc), .out_taken(out_taken),
        .out_not_branch(out_not_branch), .out_link_we(out_link_we),
        .out_link_idx(out_link_idx), .out_link_data(out_link_data)
    );

    function automatic logic [31:0] f16(input logic [5:0] op, input logic [15:0] o,
                                        input logic [4:0] j, input logic [4:0] d);
        return {op, o, j, d};
    endfunction
    function automatic logic [31:0] f21(input logic [5:0] op, input logic [20:0] o,
                                        input logic [4:0] j);
        return {op, o[15:0], j, o[20:16]};
    endfunction
    function automatic logic [31:0] f26(input logic [5:0] op, input logic [25:0] o);
        return {op, o[15:0], o[25:16]};
    endfunction

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] w;
        logic [63:0] p, a, b;
        logic [7:0]  cf;
        logic [63:0] nxt;
        logic        tk, nb, we;
        logic [4:0]  idx;
    } vec_t;

    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R4/R5 eq taken, +16
        '{4'd4, f16(6'b010110, 16'h0004, 5'd5, 5'd6), 64'h1000, 64'd7, 64'd7, 8'h0, 64'h1010, 1'b1, 1'b0, 1'b0, 5'd0},
        // R8 eq not taken
        '{4'd8, f16(6'b010110, 16'h0004, 5'd5, 5'd6), 64'h1000, 64'd7, 64'd8, 8'h0, 64'h1004, 1'b0, 1'b0, 1'b0, 5'd0},
        // R4 ne taken
        '{4'd4, f16(6'b010111, 16'h0004, 5'd5, 5'd6), 64'h1000, 64'd7, 64'd8, 8'h0, 64'h1010, 1'b1, 1'b0, 1'b0, 5'd0},
        // R4 lt signed -1 < 1, R5 offset -4
        '{4'd4, f16(6'b011000, 16'hFFFF, 5'd1, 5'd2), 64'h1000, M1, 64'd1, 8'h0, 64'h0FFC, 1'b1, 1'b0, 1'b0, 5'd0},
        // R4 ltu: all-ones not below 1
        '{4'd4, f16(6'b011010, 16'hFFFF, 5'd1, 5'd2), 64'h1000, M1, 64'd1, 8'h0, 64'h1004, 1'b0, 1'b0, 1'b0, 5'd0},
        // R5 ge signed, most negative 16-bit offset
        '{4'd5, f16(6'b011001, 16'h8000, 5'd1, 5'd2), 64'h100000, 64'd1, M1, 8'h0, 64'hE0000, 1'b1, 1'b0, 1'b0, 5'd0},
        // R4 geu: 1 not >= all-ones
        '{4'd4, f16(6'b011011, 16'h8000, 5'd1, 5'd2), 64'h100000, 64'd1, M1, 8'h0, 64'h100004, 1'b0, 1'b0, 1'b0, 5'd0},
        // R4 ge true on equality
        '{4'd4, f16(6'b011001, 16'h0002, 5'd1, 5'd2), 64'h1000, 64'd5, 64'd5, 8'h0, 64'h1008, 1'b1, 1'b0, 1'b0, 5'd0},
        // R6 zero-test, negative 21-bit offset
        '{4'd6, f21(6'b010000, 21'h100000, 5'd3), 64'h1000000, 64'd0, 64'd0, 8'h0, 64'hC00000, 1'b1, 1'b0, 1'b0, 5'd0},
        // R6 nonzero-test, high field used
        '{4'd6, f21(6'b010001, 21'h010003, 5'd3), 64'h1000, 64'd9, 64'd0, 8'h0, 64'h4100C, 1'b1, 1'b0, 1'b0, 5'd0},
        // R2 zero-test not taken
        '{4'd2, f21(6'b010000, 21'h000010, 5'd3), 64'h1000, 64'd9, 64'd0, 8'h0, 64'h1004, 1'b0, 1'b0, 1'b0, 5'd0},
        // R3 flag clear-sense, cf[3]=0
        '{4'd3, f21(6'b010010, 21'h000010, 5'b00011), 64'h1000, 64'd0, 64'd0, 8'hF7, 64'h1040, 1'b1, 1'b0, 1'b0, 5'd0},
        // R3 flag set-sense, cf[3]=0
        '{4'd3, f21(6'b010010, 21'h000010, 5'b01011), 64'h1000, 64'd0, 64'd0, 8'hF7, 64'h1004, 1'b0, 1'b0, 1'b0, 5'd0},
        // R3 flag set-sense, cf[7]=1
        '{4'd3, f21(6'b010010, 21'h000010, 5'b01111), 64'h1000, 64'd0, 64'd0, 8'h80, 64'h1040, 1'b1, 1'b0, 1'b0, 5'd0},
        // R3 reserved bits[9:8]=10
        '{4'd3, f21(6'b010010, 21'h000010, 5'b10011), 64'h1000, 64'd0, 64'd0, 8'hFF, 64'h1004, 1'b0, 1'b1, 1'b0, 5'd0},
        // R7 unconditional, offset -4
        '{4'd7, f26(6'b010100, 26'h3FFFFFF), 64'h1000, 64'd0, 64'd0, 8'h0, 64'h0FFC, 1'b1, 1'b0, 1'b0, 5'd0},
        // R7 unconditional, high field
        '{4'd7, f26(6'b010100, 26'h0010000), 64'h1000, 64'd0, 64'd0, 8'h0, 64'h41000, 1'b1, 1'b0, 1'b0, 5'd0},
        // R9 call links into register 1
        '{4'd9, f26(6'b010101, 26'h0000008), 64'h1000, 64'd0, 64'd0, 8'h0, 64'h1020, 1'b1, 1'b0, 1'b1, 5'd1},
        // R10 register jump, rd == rj
        '{4'd10, f16(6'b010011, 16'hFFFE, 5'd4, 5'd4), 64'h1000, 64'h2000, 64'h2000, 8'h0, 64'h1FF8, 1'b1, 1'b0, 1'b1, 5'd4},
        // R11 register jump into register 0: no write
        '{4'd11, f16(6'b010011, 16'h0000, 5'd4, 5'd0), 64'h1000, 64'h3000, 64'd0, 8'h0, 64'h3000, 1'b1, 1'b0, 1'b0, 5'd0},
        // R1 non-branch opcode 000000
        '{4'd1, 32'h0000_1234, 64'h1000, 64'd0, 64'd0, 8'h0, 64'h1004, 1'b0, 1'b1, 1'b0, 5'd0},
        // R1 opcode 011100 just past the group
        '{4'd1, f16(6'b011100, 16'h0004, 5'd0, 5'd0), 64'h1000, 64'd0, 64'd0, 8'h0, 64'h1004, 1'b0, 1'b1, 1'b0, 5'd0}
    };

    task automatic check(input int rq, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        insn = v.w; pc = v.p; rj_val = v.a; rd_val = v.b; cflags = v.cf;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; insn = '0; pc = '0;
        rj_val = '0; rd_val = '0; cflags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(12, "reset valid", 64'(out_valid), 64'd0);  // R12
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk); @(negedge clk);
            check(12, $sformatf("v%0d valid", i), 64'(out_valid), 64'd1);
            check(VECS[i].rq, $sformatf("v%0d next_pc", i), out_next_pc, VECS[i].nxt);
            check(VECS[i].rq, $sformatf("v%0d taken", i), 64'(out_taken), 64'(VECS[i].tk));
            check(VECS[i].rq, $sformatf("v%0d not_branch", i), 64'(out_not_branch), 64'(VECS[i].nb));
            check(VECS[i].rq, $sformatf("v%0d link_we", i), 64'(out_link_we), 64'(VECS[i].we));
            if (VECS[i].we) begin
                check(VECS[i].rq, $sformatf("v%0d link_idx", i), 64'(out_link_idx), 64'(VECS[i].idx));
                check(VECS[i].rq, $sformatf("v%0d link_data", i), out_link_data, VECS[i].p + 64'd4);
            end
        end

        // R12: idle cycle drops valid and holds the result fields
        in_valid = 1'b0;
        insn = f26(6'b010100, 26'h0000100); pc = 64'h8000;
        @(posedge clk); @(negedge clk);
        check(12, "idle valid", 64'(out_valid), 64'd0);
        check(12, "idle hold next_pc", out_next_pc, 64'h1004);
        check(12, "idle hold not_branch", 64'(out_not_branch), 64'd1);

        // R9: back-to-back call then compare, link request clears
        drive(VECS[17]);
        @(posedge clk); @(negedge clk);
        check(9, "b2b call we", 64'(out_link_we), 64'd1);
        drive(VECS[0]);
        @(posedge clk); @(negedge clk);
        check(9, "b2b after call we", 64'(out_link_we), 64'd0);
        check(4, "b2b eq next_pc", out_next_pc, 64'h1010);

        // R12: reset with a valid input still clears out_valid
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(12, "reset over valid", 64'(out_valid), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk); @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule